// File: doc/BRIEF.md
# Head Switch and Recovery Interlock

This block sits between a disk sequencer and the drive interface. The sequencer raises level requests for the read gate and the write gate, and pulses a head-change request that carries the new head number. The block grants a gate only after every recovery window tied to that gate has run out. It holds a request that arrives too early until its window expires; it does not drop it. It never lets read and write be active together.

The windows are counted from single-cycle tick inputs. One tick marks each microsecond and another marks each servo clock period. Each window restarts on the edge that starts it: the falling edge of a gate, or the head-select strobe.

A head change turns off both gates at once. The block then waits until write has been off for the set number of microseconds. It then pulses a head-select strobe and presents the new head number. A busy output tells the sequencer that a head change is pending or that some window is still running.

Top module: `head_guard`

## Requirements
- R1: rd_gate and wr_gate are never 1 together. When both requests are eligible from idle in the same cycle, read is granted and write is held. A request for one gate is held while the other gate is active.
- R2: head_strobe is a one-cycle pulse. It rises only after wr_gate has been 0 for at least WOFF_US us_tick pulses (default 1). In the cycle it is high, head_sel carries the head number taken from hs_head with the latest hs_req.
- R3: wr_gate does not rise until HS_WR_US us_tick pulses (default 5) have been counted after head_strobe.
- R4: rd_gate does not rise until HS_RD_US us_tick pulses (default 15) have been counted after head_strobe.
- R5: rd_gate does not rise until W2R_US us_tick pulses (default 10) have been counted after wr_gate falls.
- R6: wr_gate does not rise until R2W_SV servo_tick pulses (default 5) have been counted after rd_gate falls.
- R7: A request that is blocked stays pending. Its gate rises the cycle after the tick that completes the last window. A granted gate stays high while its request is held and falls the cycle after the request drops.
- R8: A cycle with hs_req high forces both gates to 0 on the next cycle. No gate is granted again until the head strobe has been issued.
- R9: After reset the gates, head_strobe, head_sel and busy are 0. Every window counts as elapsed, so a request made right after reset is granted on the next cycle.
- R10: busy is 1 while a head change is pending or any recovery window is still running. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| servo_tick | input | 1 | One-cycle pulse per servo clock period |
| rd_req | input | 1 | Read gate request (level) |
| wr_req | input | 1 | Write gate request (level) |
| hs_req | input | 1 | Head-change request (one-cycle pulse) |
| hs_head | input | HEAD_W | Head number to select, taken with hs_req |
| rd_gate | output | 1 | Granted read enable |
| wr_gate | output | 1 | Granted write enable |
| head_strobe | output | 1 | One-cycle head-select strobe |
| head_sel | output | HEAD_W | Selected head number |
| busy | output | 1 | Head change pending or a window running |

## Verification
The assertions assume that us_tick, servo_tick and hs_req are single-cycle pulses that are synchronous to clk. The checker keeps its own tick counters, driven only from the gate and strobe ports, and compares every gate rise and every strobe against them.

The stimulus sends each tick as a one-cycle pulse followed by an idle cycle, and sends hs_req for one cycle only. It changes requests only on the falling clock edge. It places ticks just below and just at each window limit so that both sides of every boundary are observed.

// File: rtl/head_guard_pkg.sv
package head_guard_pkg;

  // Elapsed flags for each recovery window, one per grant rule.
  typedef struct packed {
    logic wf_off;  // write off long enough to switch heads
    logic wf_rd;   // write-to-read recovery done
    logic hs_wr;   // head settle for write done
    logic hs_rd;   // head settle for read done
    logic rf_wr;   // read-to-write recovery done
  } win_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hg_recov_timer.sv
// Saturating tick counter; sits at SAT (window elapsed) until restarted.
module hg_recov_timer #(
  parameter int unsigned SAT = 15,
  localparam int unsigned CW = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          idle
);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CW'(SAT);
    else if (restart)
      cnt <= '0;
    else if (tick && (cnt != CW'(SAT)))
      cnt <= cnt + 1'b1;
  end

  assign idle = (cnt == CW'(SAT));

endmodule

// File: rtl/hg_arbiter.sv
// Grant arbiter: registered gates, head-change sequencing.
module hg_arbiter
  import head_guard_pkg::*;
#(
  parameter int unsigned HEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              hs_req,
  input  logic [HEAD_W-1:0] hs_head,
  input  win_t              win,
  output logic              rd_gate,
  output logic              wr_gate,
  output logic              head_strobe,
  output logic [HEAD_W-1:0] head_sel,
  output logic              hs_pend,
  output logic              rd_fall,
  output logic              wr_fall,
  output logic              hs_restart
);

  logic [HEAD_W-1:0] tgt;
  logic blk, rd_ok, wr_ok, strb;

  always_comb begin
    blk   = hs_pend | hs_req;
    rd_ok = rd_req & ~blk & ~wr_gate & (rd_gate | (win.hs_rd & win.wf_rd));
    wr_ok = wr_req & ~blk & ~rd_gate & ~rd_ok & (wr_gate | (win.hs_wr & win.rf_wr));
    strb  = hs_pend & ~head_strobe & ~wr_gate & ~rd_gate & win.wf_off;
    rd_fall    = rd_gate & ~rd_ok;
    wr_fall    = wr_gate & ~wr_ok;
    // settle window held at zero through the strobe cycle
    hs_restart = strb | head_strobe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_gate     <= 1'b0;
      wr_gate     <= 1'b0;
      head_strobe <= 1'b0;
      hs_pend     <= 1'b0;
      tgt         <= '0;
      head_sel    <= '0;
    end else begin
      rd_gate     <= rd_ok;
      wr_gate     <= wr_ok;
      head_strobe <= strb;
      hs_pend     <= hs_req | (hs_pend & ~strb);
      if (hs_req) tgt <= hs_head;
      if (strb) head_sel <= tgt;
    end
  end

endmodule

// File: rtl/head_guard.sv
module head_guard
  import head_guard_pkg::*;
#(
  parameter int unsigned HEAD_W   = 4,
  parameter int unsigned WOFF_US  = 1,
  parameter int unsigned HS_WR_US = 5,
  parameter int unsigned HS_RD_US = 15,
  parameter int unsigned W2R_US   = 10,
  parameter int unsigned R2W_SV   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              us_tick,
  input  logic              servo_tick,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              hs_req,
  input  logic [HEAD_W-1:0] hs_head,
  output logic              rd_gate,
  output logic              wr_gate,
  output logic              head_strobe,
  output logic [HEAD_W-1:0] head_sel,
  output logic              busy
);

  localparam int unsigned WF_SAT = max2(WOFF_US, W2R_US);
  localparam int unsigned HS_SAT = max2(HS_WR_US, HS_RD_US);
  localparam int unsigned RF_SAT = R2W_SV;
  localparam int unsigned WF_CW  = $clog2(WF_SAT + 1);
  localparam int unsigned HS_CW  = $clog2(HS_SAT + 1);
  localparam int unsigned RF_CW  = $clog2(RF_SAT + 1);

  logic [WF_CW-1:0] wf_cnt;
  logic [HS_CW-1:0] hs_cnt;
  logic [RF_CW-1:0] rf_cnt;
  logic wf_idle, hs_idle, rf_idle;
  logic hs_pend, rd_fall, wr_fall, hs_restart;
  win_t win;

  // since write fell (us)
  hg_recov_timer #(.SAT(WF_SAT)) u_wf (
    .clk(clk), .rst(rst), .restart(wr_fall), .tick(us_tick),
    .cnt(wf_cnt), .idle(wf_idle)
  );

  // since head strobe (us)
  hg_recov_timer #(.SAT(HS_SAT)) u_hs (
    .clk(clk), .rst(rst), .restart(hs_restart), .tick(us_tick),
    .cnt(hs_cnt), .idle(hs_idle)
  );

  // since read fell (servo periods)
  hg_recov_timer #(.SAT(RF_SAT)) u_rf (
    .clk(clk), .rst(rst), .restart(rd_fall), .tick(servo_tick),
    .cnt(rf_cnt), .idle(rf_idle)
  );

  always_comb begin
    win.wf_off = (wf_cnt >= WF_CW'(WOFF_US));
    win.wf_rd  = (wf_cnt >= WF_CW'(W2R_US));
    win.hs_wr  = (hs_cnt >= HS_CW'(HS_WR_US));
    win.hs_rd  = (hs_cnt >= HS_CW'(HS_RD_US));
    win.rf_wr  = (rf_cnt >= RF_CW'(R2W_SV));
  end

  hg_arbiter #(.HEAD_W(HEAD_W)) u_arb (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .wr_req(wr_req), .hs_req(hs_req), .hs_head(hs_head),
    .win(win),
    .rd_gate(rd_gate), .wr_gate(wr_gate), .head_strobe(head_strobe),
    .head_sel(head_sel), .hs_pend(hs_pend),
    .rd_fall(rd_fall), .wr_fall(wr_fall), .hs_restart(hs_restart)
  );

  assign busy = hs_pend | ~(wf_idle & hs_idle & rf_idle);

endmodule

// File: rtl/hg_checker.sv
module hg_checker #(
  parameter int unsigned WOFF_US  = 1,
  parameter int unsigned HS_WR_US = 5,
  parameter int unsigned HS_RD_US = 15,
  parameter int unsigned W2R_US   = 10,
  parameter int unsigned R2W_SV   = 5
) (
  input logic clk,
  input logic rst,
  input logic us_tick,
  input logic servo_tick,
  input logic hs_req,
  input logic rd_gate,
  input logic wr_gate,
  input logic head_strobe
);

  localparam int unsigned CAP = 32'h000F_FFFF;

  // Independent tick counts derived from the output ports only.
  int unsigned c_wf, c_hs, c_rf;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_wf <= CAP;
      c_hs <= CAP;
      c_rf <= CAP;
    end else begin
      if (wr_gate) c_wf <= 0;
      else if (us_tick && c_wf < CAP) c_wf <= c_wf + 1;
      if (head_strobe) c_hs <= 0;
      else if (us_tick && c_hs < CAP) c_hs <= c_hs + 1;
      if (rd_gate) c_rf <= 0;
      else if (servo_tick && c_rf < CAP) c_rf <= c_rf + 1;
    end
  end

  AST_GATE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_gate && wr_gate)); // R1

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    head_strobe |=> !head_strobe); // R2

  AST_STROBE_WOFF: assert property (@(posedge clk) disable iff (rst)
    $rose(head_strobe) |-> (!$past(wr_gate) && ($past(c_wf) >= WOFF_US))); // R2

  AST_WR_HEAD_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_gate) |-> ($past(c_hs) >= HS_WR_US)); // R3

  AST_RD_HEAD_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_gate) |-> ($past(c_hs) >= HS_RD_US)); // R4

  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_gate) |-> ($past(c_wf) >= W2R_US)); // R5

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_gate) |-> ($past(c_rf) >= R2W_SV)); // R6

  AST_HEAD_DROPS_GATES: assert property (@(posedge clk) disable iff (rst)
    hs_req |=> (!rd_gate && !wr_gate)); // R8

endmodule

bind head_guard hg_checker #(
  .WOFF_US(WOFF_US), .HS_WR_US(HS_WR_US), .HS_RD_US(HS_RD_US),
  .W2R_US(W2R_US), .R2W_SV(R2W_SV)
) u_chk (
  .clk(clk), .rst(rst), .us_tick(us_tick), .servo_tick(servo_tick),
  .hs_req(hs_req), .rd_gate(rd_gate), .wr_gate(wr_gate),
  .head_strobe(head_strobe)
);

// File: tb/tb_head_guard.sv
module tb_head_guard;

  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick = 1'b0, servo_tick = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, hs_req = 1'b0;
  logic [3:0] hs_head = '0;
  logic rd_gate, wr_gate, head_strobe, busy;
  logic [3:0] head_sel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  head_guard dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .servo_tick(servo_tick),
    .rd_req(rd_req), .wr_req(wr_req), .hs_req(hs_req), .hs_head(hs_head),
    .rd_gate(rd_gate), .wr_gate(wr_gate), .head_strobe(head_strobe),
    .head_sel(head_sel), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nx(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic us(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1; @(negedge clk);
      us_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic sv(input int n);
    for (int i = 0; i < n; i++) begin
      servo_tick = 1'b1; @(negedge clk);
      servo_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; nx(3); rst = 1'b0; nx(1);
  endtask

  task automatic t_reset_state;
    do_reset();
    chk("R9 rd_gate after reset", rd_gate, 0);
    chk("R9 wr_gate after reset", wr_gate, 0);
    chk("R9 head_strobe after reset", head_strobe, 0);
    chk("R9 head_sel after reset", head_sel, 0);
    chk("R10 busy idle after reset", busy, 0);
  endtask

  task automatic t_read_then_write;
    rd_req = 1'b1; nx(1);
    chk("R9 read granted at once after reset", rd_gate, 1);
    nx(3);
    chk("R7 read held while requested", rd_gate, 1);
    wr_req = 1'b1; nx(2);
    chk("R1 write held during read", wr_gate, 0);
    chk("R1 read stays on", rd_gate, 1);
    rd_req = 1'b0; nx(1);
    chk("R7 read drops after request", rd_gate, 0);
    sv(4); nx(1);
    chk("R6 write blocked after 4 servo ticks", wr_gate, 0);
    sv(1);
    chk("R6 write granted after 5 servo ticks", wr_gate, 1);
    chk("R1 read off with write", rd_gate, 0);
  endtask

  task automatic t_write_to_read;
    rd_req = 1'b1; nx(2);
    chk("R1 read held during write", rd_gate, 0);
    chk("R1 write stays on", wr_gate, 1);
    wr_req = 1'b0; nx(1);
    chk("R7 write drops after request", wr_gate, 0);
    chk("R10 busy while window runs", busy, 1);
    us(9);
    chk("R5 read blocked after 9 us", rd_gate, 0);
    us(1);
    chk("R5 read granted after 10 us", rd_gate, 1);
    rd_req = 1'b0; nx(1);
  endtask

  task automatic t_head_during_write;
    sv(5);
    wr_req = 1'b1; nx(1);
    chk("R6 write granted after read window", wr_gate, 1);
    hs_head = 4'd3; hs_req = 1'b1; nx(1);
    hs_req = 1'b0;
    chk("R8 head request drops write", wr_gate, 0);
    chk("R10 busy with head pending", busy, 1);
    chk("R2 no strobe before off window", head_strobe, 0);
    nx(3);
    chk("R2 still no strobe without tick", head_strobe, 0);
    chk("R8 write stays blocked while pending", wr_gate, 0);
    us(1);
    chk("R2 strobe after write off 1 us", head_strobe, 1);
    chk("R2 head_sel carries new head", head_sel, 3);
    nx(1);
    chk("R2 strobe lasts one cycle", head_strobe, 0);
    us(4);
    chk("R3 write blocked 4 us after strobe", wr_gate, 0);
    us(1);
    chk("R3 write granted 5 us after strobe", wr_gate, 1);
  endtask

  task automatic t_head_then_read;
    hs_head = 4'd5; hs_req = 1'b1; wr_req = 1'b0; nx(1);
    hs_req = 1'b0;
    chk("R8 gates off after head request", wr_gate, 0);
    us(1);
    chk("R2 strobe for second head", head_strobe, 1);
    chk("R2 head_sel second head", head_sel, 5);
    nx(1);
    rd_req = 1'b1;
    us(14);
    chk("R4 read blocked 14 us after strobe", rd_gate, 0);
    us(1);
    chk("R4 read granted 15 us after strobe", rd_gate, 1);
    rd_req = 1'b0; nx(1);
  endtask

  task automatic t_reset_priority;
    do_reset();
    chk("R9 head_sel cleared by reset", head_sel, 0);
    chk("R10 busy clear after reset", busy, 0);
    rd_req = 1'b1; wr_req = 1'b1; nx(1);
    chk("R1 read wins from idle", rd_gate, 1);
    chk("R1 write held on tie", wr_gate, 0);
    rd_req = 1'b0; wr_req = 1'b0; nx(1);
  endtask

  initial begin
    t_reset_state();
    t_read_then_write();
    t_write_to_read();
    t_head_during_write();
    t_head_then_read();
    t_reset_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule